// File: doc/BRIEF.md
# Hysteresis Threshold Gate

This block models a single threshold gate with hysteresis as a clocked state element, so that asynchronous-style logic can be built, synthesized and simulated in a clocked flow. The gate has one to four inputs, and each input carries its own integer weight. The gate's state rises when the weighted count of high inputs reaches a threshold. Once risen, the state stays high as long as any input is still high. It falls only when every input has returned to zero. The state update is next = set OR (state AND hold). Here set is the threshold test and hold is the OR of all inputs. Because of the hold term, the gate remembers its state and is not a plain majority function.

Parameters select the input count, the threshold, the weight of each input, the state that reset forces, and whether the output is the complement of the state. Two configurations fall out of the same description. When the threshold equals the number of unit-weight inputs, the gate acts as a C-element. With a threshold of one, it reduces to an OR gate with no memory. A parameter set whose weights cannot reach the threshold stops elaboration. So does an input count outside one to four, or a weight of zero.

Top module: `thg_gate`

## Requirements
- R1: While the active-low reset `rstN` is low, the internal state equals parameter `RESET_VAL`. The output `gateOut` shows that state, complemented when `INVERT` is 1. Reset takes effect without waiting for a clock edge.
- R2: Input `din[i]` counts with the weight held in `WEIGHTS[i*WGT_W +: WGT_W]`. When the sum of the weights of the high inputs is at least `THRESH`, the state is 1 after the next rising clock edge.
- R3: While the state is 1 and at least one input is high, the state stays 1 after the next edge, even when the weighted count is below `THRESH`.
- R4: When all inputs are 0, the state is 0 after the next edge.
- R5: While the state is 0 and the weighted count is below `THRESH`, the state stays 0 after the next edge, even with some inputs high.
- R6: With four inputs, threshold 3 and `din[0]` of weight 2 (the others weight 1), the gate sets exactly when din[0]&(din[1]|din[2]|din[3]) | din[1]&din[2]&din[3].
- R7: With three unit-weight inputs and threshold 3, the gate behaves as a C-element. It rises only when all inputs are 1, falls only when all are 0, and otherwise holds.
- R8: With threshold 1, the state after each edge equals the OR of the inputs sampled at that edge, whatever the prior state.
- R9: With `INVERT` = 1, `gateOut` is the complement of the state described in R1 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at which the state is re-evaluated |
| rstN | input | 1 | Asynchronous active-low reset to `RESET_VAL` |
| din | input | NUM_IN | Gate inputs; bit 0 takes the lowest weight field |
| gateOut | output | 1 | Gate output, optionally inverted |

## Verification
The bench builds four instances of the gate. The first has four inputs, threshold 3 and a double-weight first input; all sixteen input patterns are applied to it from a cleared state, so every term of the weighted set function is reached. The second is a three-input majority gate with a hold, and the third is a three-input C-element that resets to 1. The fourth is an inverting two-input threshold-one gate. Between them they cover hysteresis, reset to either value, the memory-less OR case and the inverted output. A reset applied mid-run confirms that it acts at once, without a clock edge.

// File: rtl/thg_pkg.sv
package thg_pkg;
  localparam int MAX_IN = 4;

  // strobes handed from the evaluator to the state holder
  typedef struct packed {
    logic setHit;   // weighted count reached the threshold
    logic holdAny;  // at least one input is high
  } gateStrobe_t;
endpackage

// File: rtl/thg_eval.sv
module thg_eval
  import thg_pkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int THRESH = 2,
  parameter int WGT_W = 3,
  parameter logic [MAX_IN*WGT_W-1:0] WEIGHTS = 12'h249
) (
  input  logic [NUM_IN-1:0] din,
  output gateStrobe_t       strb
);
  localparam int MAX_WGT = (1 << WGT_W) - 1;
  localparam int SUM_W = $clog2(NUM_IN * MAX_WGT + 1);

  function automatic int totalWeight();
    int acc = 0;
    for (int i = 0; i < NUM_IN; i++) acc += int'(WEIGHTS[i*WGT_W +: WGT_W]);
    return acc;
  endfunction

  function automatic bit hasZeroWeight();
    bit z = 1'b0;
    for (int i = 0; i < NUM_IN; i++)
      if (WEIGHTS[i*WGT_W +: WGT_W] == '0) z = 1'b1;
    return z;
  endfunction

  localparam int TOTAL_WGT = totalWeight();

  // reject configurations that can never set or are out of range
  if (NUM_IN < 1 || NUM_IN > MAX_IN) begin : g_badCount
    $error("thg_eval: input count out of range");
  end
  if (THRESH < 1 || TOTAL_WGT < THRESH) begin : g_badThresh
    $error("thg_eval: threshold unreachable by the weights");
  end
  if (hasZeroWeight()) begin : g_badWeight
    $error("thg_eval: zero weight on an input");
  end

  logic [SUM_W-1:0] term [NUM_IN];
  logic [SUM_W-1:0] weightSum;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_term
    assign term[i] = din[i] ? SUM_W'(WEIGHTS[i*WGT_W +: WGT_W]) : '0;
  end

  always_comb begin
    weightSum = '0;
    for (int i = 0; i < NUM_IN; i++) weightSum = weightSum + term[i];
  end

  assign strb.setHit  = (int'(weightSum) >= THRESH);
  assign strb.holdAny = |din;
endmodule

// File: rtl/thg_state.sv
module thg_state
  import thg_pkg::*;
#(
  parameter bit RESET_VAL = 1'b0,
  parameter bit INVERT = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  gateStrobe_t strb,
  output logic        stateQ,
  output logic        gateOut
);
  // next = set | (prev & hold)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= RESET_VAL;
    else       stateQ <= strb.setHit | (stateQ & strb.holdAny);
  end

  if (INVERT) begin : g_inv
    assign gateOut = ~stateQ;
  end else begin : g_pass
    assign gateOut = stateQ;
  end
endmodule

// File: rtl/thg_gate.sv
module thg_gate
  import thg_pkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int THRESH = 2,
  parameter int WGT_W = 3,
  parameter logic [MAX_IN*WGT_W-1:0] WEIGHTS = 12'h249,
  parameter bit RESET_VAL = 1'b0,
  parameter bit INVERT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] din,
  output logic              gateOut
);
  gateStrobe_t strb;
  logic        stateQ;

  thg_eval #(
    .NUM_IN (NUM_IN),
    .THRESH (THRESH),
    .WGT_W  (WGT_W),
    .WEIGHTS(WEIGHTS)
  ) u_eval (
    .din (din),
    .strb(strb)
  );

  thg_state #(
    .RESET_VAL(RESET_VAL),
    .INVERT   (INVERT)
  ) u_state (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .stateQ (stateQ),
    .gateOut(gateOut)
  );
endmodule

// File: rtl/thg_gate_chk.sv
module thg_gate_chk
  import thg_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input gateStrobe_t strb,
  input logic        stateQ
);
  // R2
  set_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setHit |=> stateQ);

  // R3
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ && strb.holdAny) |=> stateQ);

  // R4
  all_low_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.holdAny |=> !stateQ);

  // R5
  low_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stateQ && !strb.setHit) |=> !stateQ);
endmodule

bind thg_gate thg_gate_chk u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .strb  (strb),
  .stateQ(stateQ)
);

// File: tb/tb_thg_gate.sv
module tb_thg_gate;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] inA = '0;
  logic [2:0] inMaj = '0;
  logic [2:0] inC = '0;
  logic [1:0] inOr = '0;
  logic outA, outMaj, outC, outOr;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // four inputs, threshold 3, din[0] weight 2
  thg_gate #(.NUM_IN(4), .THRESH(3), .WGT_W(3), .WEIGHTS(12'h24A),
             .RESET_VAL(1'b0), .INVERT(1'b0))
    dut (.clk(clk), .rstN(rstN), .din(inA), .gateOut(outA));

  thg_gate #(.NUM_IN(3), .THRESH(2), .WGT_W(3), .WEIGHTS(12'h249),
             .RESET_VAL(1'b0), .INVERT(1'b0))
    dutMaj (.clk(clk), .rstN(rstN), .din(inMaj), .gateOut(outMaj));

  thg_gate #(.NUM_IN(3), .THRESH(3), .WGT_W(3), .WEIGHTS(12'h249),
             .RESET_VAL(1'b1), .INVERT(1'b0))
    dutC (.clk(clk), .rstN(rstN), .din(inC), .gateOut(outC));

  thg_gate #(.NUM_IN(2), .THRESH(1), .WGT_W(3), .WEIGHTS(12'h249),
             .RESET_VAL(1'b0), .INVERT(1'b1))
    dutOr (.clk(clk), .rstN(rstN), .din(inOr), .gateOut(outOr));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // inputs are set at a falling edge; one rising edge passes; sample at the next fall
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tReset();
    @(negedge clk); @(negedge clk);
    chk("R1 weighted gate resets to 0", outA, 1'b0);
    chk("R1 majority gate resets to 0", outMaj, 1'b0);
    chk("R1 C-element resets to 1", outC, 1'b1);
    chk("R9 inverted output during reset", outOr, 1'b1);
    rstN = 1'b1;
    step();
    chk("R4 C-element clears after reset with inputs low", outC, 1'b0);
  endtask

  task automatic tWeighted();
    for (int p = 0; p < 16; p++) begin
      logic [3:0] v;
      logic e;
      v = 4'(p);
      inA = 4'b0000; step();
      inA = v; step();
      e = (v[0] & (v[1] | v[2] | v[3])) | (v[1] & v[2] & v[3]);
      chk($sformatf("R6 R2 weighted set pattern %b", v), outA, e);
    end
    inA = 4'b0000; step();
  endtask

  task automatic tHysteresis();
    inA = 4'b0011; step(); chk("R2 weighted set A+B", outA, 1'b1);
    inA = 4'b0010; step(); chk("R3 hold with count 1", outA, 1'b1);
    inA = 4'b1000; step(); chk("R3 hold with other input", outA, 1'b1);
    inA = 4'b0000; step(); chk("R4 clear on all low", outA, 1'b0);
    inA = 4'b0010; step(); chk("R5 stays low below threshold", outA, 1'b0);
    inA = 4'b0000; step();
  endtask

  task automatic tMajority();
    inMaj = 3'b001; step(); chk("R5 majority one input stays low", outMaj, 1'b0);
    inMaj = 3'b011; step(); chk("R2 majority two inputs set", outMaj, 1'b1);
    inMaj = 3'b100; step(); chk("R3 majority holds on one input", outMaj, 1'b1);
    inMaj = 3'b000; step(); chk("R4 majority clears", outMaj, 1'b0);
    inMaj = 3'b101; step(); chk("R2 majority sets on A and C", outMaj, 1'b1);
    inMaj = 3'b000; step(); chk("R4 majority clears again", outMaj, 1'b0);
  endtask

  task automatic tCElement();
    inC = 3'b011; step(); chk("R7 partial stays low", outC, 1'b0);
    inC = 3'b111; step(); chk("R7 all high sets", outC, 1'b1);
    inC = 3'b001; step(); chk("R7 partial holds high", outC, 1'b1);
    inC = 3'b000; step(); chk("R7 all low clears", outC, 1'b0);
    inC = 3'b110; step(); chk("R7 partial keeps low", outC, 1'b0);
    inC = 3'b000; step();
  endtask

  task automatic tOrGate();
    inOr = 2'b01; step(); chk("R8 R9 one input high", outOr, 1'b0);
    inOr = 2'b00; step(); chk("R8 R9 all low", outOr, 1'b1);
    inOr = 2'b10; step(); chk("R8 R9 other input high", outOr, 1'b0);
    inOr = 2'b11; step(); chk("R8 R9 both high", outOr, 1'b0);
    inOr = 2'b00; step(); chk("R8 no memory once low", outOr, 1'b1);
  endtask

  task automatic tMidReset();
    inA = 4'b0011; step();
    chk("R2 set before mid-run reset", outA, 1'b1);
    rstN = 1'b0;
    #1;
    chk("R1 reset clears without clock", outA, 1'b0);
    chk("R1 reset forces C-element to 1", outC, 1'b1);
    inA = 4'b0000;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 C-element holds reset value until edge", outC, 1'b1);
    @(negedge clk);
  endtask

  initial begin
    tReset();
    tWeighted();
    tHysteresis();
    tMajority();
    tCElement();
    tOrGate();
    tMidReset();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule